// File: doc/BRIEF.md
# Cache Line Fill Qualifier

This block decides, beat by beat, whether a burst read from memory is written into an on-chip cache and which write policy the new line gets. It keeps two control bits. The first is a cache-off bit, `cd`: a value of 1 disables caching. The second is a write-through-off bit, `nw`: a value of 1 disables write-through. While a four-doubleword burst is in progress, the block drives a one-hot write strobe per beat for the cache data array. After the last beat it raises a one-cycle line-allocate pulse, together with the write-through flag of the filled line. The tag store uses that pulse to set the line's valid bit.

Caching is decided once per burst. The decision uses the cache-enable and policy inputs as seen on the first burst-ready beat. A hard reset sets both control bits and requests an invalidation of the whole cache. A soft reset only abandons the fill in progress. A small helper output tells the store path whether a processor write must also go out on the external bus.

Top module: `linefill_qual`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `inval` is 1. After that first cycle `inval` is 0. Hard reset sets `cd_o` and `nw_o` to 1.
- R2: A soft reset (`soft_rst` = 1) has these effects:
  - It leaves `cd_o` and `nw_o` unchanged and does not raise `inval`.
  - It suppresses `fill_we_vec` in its own cycle.
  - It abandons any burst in progress without a `line_alloc` pulse. The next burst starts from its first beat.
- R3: When `ctl_wr` is 1, `cd_o` and `nw_o` take the values of `cd_in` and `nw_in` at the next clock edge. This applies even when `soft_rst` is also 1.
- R4: When `ken` is 1 and `cd_o` is 0 on the first `brdy` after `rd_start`, each of the four `brdy` beats raises `fill_we_vec` combinationally in that beat's cycle. Beat k (k = 0 to 3, in order) raises bit k only.
- R5: When `ken` is 0 on the first `brdy`, no bit of `fill_we_vec` rises for the whole burst and no `line_alloc` follows. This holds even if `ken` is 1 on later beats. The value of `ken` on later beats of a filling burst has no effect.
- R6: When `cd_o` is 1 at the first `brdy`, no bit of `fill_we_vec` rises and no `line_alloc` follows.
- R7: `line_alloc` is 1 for exactly the one cycle after the fourth strobed beat, and at no other time.
- R8: When `line_alloc` is 1, `line_wt` is 1 exactly when `wbwt` was 0 and `nw_o` was 0 on the first `brdy`. The value of `wbwt` on later beats is ignored.
- R9: An `rdy` (non-burst ready) ends the cycle: either on the first beat, which makes it a single read, or partway through a burst. No further strobes follow, no `line_alloc` is issued, and the block returns to idle. `rdy` wins over a simultaneous `brdy`.
- R10: `wr_bus` is 1 for any processor write that misses (`wr_hit` = 0) or that hits a write-through line (`wr_line_wt` = 1). It is 0 only for a hit on a line that is not write-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| ctl_wr | input | 1 | Load enable for the control bits |
| cd_in | input | 1 | New cache-off bit |
| nw_in | input | 1 | New write-through-off bit |
| rd_start | input | 1 | Start of a cacheable-candidate read cycle |
| rdy | input | 1 | Non-burst ready, ends the cycle |
| brdy | input | 1 | Burst ready, one per beat |
| ken | input | 1 | Cache enable from the system, active high |
| wbwt | input | 1 | Policy input: 1 write-back, 0 write-through |
| wr_hit | input | 1 | Processor write hits a cached line |
| wr_line_wt | input | 1 | The hit line is write-through |
| cd_o | output | 1 | Current cache-off bit |
| nw_o | output | 1 | Current write-through-off bit |
| inval | output | 1 | Whole-cache invalidate request |
| fill_we_vec | output | 4 | One-hot write strobe per beat for the data array |
| line_alloc | output | 1 | One-cycle pulse: set the line valid |
| line_wt | output | 1 | Write-through flag of the allocated line |
| wr_bus | output | 1 | Processor write must also go on the external bus |

## Verification
Two events can land in the same cycle: a soft reset and the fourth `brdy` of a filling burst. The bench raises both together after three strobed beats. It then checks three things: no strobe appears in that cycle, no `line_alloc` follows in the next cycle, and the control bits and `inval` are unchanged. A fresh burst run immediately afterwards must allocate normally, which proves the beat counter was cleared. A `ctl_wr` issued together with `soft_rst` is also judged, by reading `cd_o` and `nw_o` in the following cycle.

// File: rtl/lfq_pkg.sv
package lfq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_FILL  = 2'd2,
      ST_SKIP  = 2'd3
   } lfq_state_e;

endpackage

// File: rtl/lfq_ctl_regs.sv
module lfq_ctl_regs #(
   parameter bit CD_RST = 1'b1,
   parameter bit NW_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic cd_in,
   input  logic nw_in,
   output logic cd_q,
   output logic nw_q,
   output logic inval
);

   logic inval_q;

   // Control bits survive soft reset: only the hard reset touches them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd_q <= CD_RST;
         nw_q <= NW_RST;
      end else if (ctl_wr) begin
         cd_q <= cd_in;
         nw_q <= nw_in;
      end
   end

   // Invalidate request: held through reset and for the first cycle after.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inval_q <= 1'b1;
      else        inval_q <= 1'b0;
   end

   assign inval = inval_q;

endmodule

// File: rtl/lfq_fsm.sv
module lfq_fsm
   import lfq_pkg::*;
#(
   parameter int BEATS = 4,
   localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             rd_start,
   input  logic             rdy,
   input  logic             brdy,
   input  logic             ken,
   input  logic             wbwt,
   input  logic             cd,
   input  logic             nw,
   output logic             we_en,
   output logic [IDX_W-1:0] beat_idx,
   output logic             line_alloc,
   output logic             line_wt
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

   lfq_state_e       st_q;
   logic [IDX_W-1:0] cnt_q;
   logic             wt_pend_q;
   logic             alloc_q;
   logic             wt_q;
   logic             beat_ok;
   logic             first_cacheable;

   assign beat_ok         = brdy && !rdy;
   assign first_cacheable = ken && !cd;

   always_comb begin
      we_en = 1'b0;
      if (!soft_rst && beat_ok) begin
         unique case (st_q)
            ST_FIRST: we_en = first_cacheable;
            ST_FILL:  we_en = 1'b1;
            default:  we_en = 1'b0;
         endcase
      end
   end

   assign beat_idx = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         wt_pend_q <= 1'b0;
         alloc_q   <= 1'b0;
         wt_q      <= 1'b0;
      end else begin
         alloc_q <= 1'b0;
         if (soft_rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  cnt_q <= '0;
                  if (rd_start) st_q <= ST_FIRST;
               end
               ST_FIRST: begin
                  if (rdy) begin
                     st_q <= ST_IDLE;
                  end else if (brdy) begin
                     cnt_q     <= IDX_W'(1);
                     wt_pend_q <= !wbwt && !nw;
                     st_q      <= first_cacheable ? ST_FILL : ST_SKIP;
                  end
               end
               ST_FILL, ST_SKIP: begin
                  if (rdy) begin
                     st_q  <= ST_IDLE;
                     cnt_q <= '0;
                  end else if (brdy) begin
                     if (cnt_q == LAST) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                        if (st_q == ST_FILL) begin
                           alloc_q <= 1'b1;
                           wt_q    <= wt_pend_q;
                        end
                     end else begin
                        cnt_q <= cnt_q + IDX_W'(1);
                     end
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign line_alloc = alloc_q;
   assign line_wt    = wt_q;

endmodule

// File: rtl/lfq_strobe.sv
module lfq_strobe #(
   parameter int BEATS = 4,
   localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             we_en,
   input  logic [IDX_W-1:0] beat_idx,
   output logic [BEATS-1:0] we_vec
);

   for (genvar i = 0; i < BEATS; i++) begin : g_lane
      assign we_vec[i] = we_en && (beat_idx == IDX_W'(i));
   end

endmodule

// File: rtl/linefill_qual.sv
module linefill_qual #(
   parameter int BEATS  = 4,
   parameter bit CD_RST = 1'b1,
   parameter bit NW_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             ctl_wr,
   input  logic             cd_in,
   input  logic             nw_in,
   input  logic             rd_start,
   input  logic             rdy,
   input  logic             brdy,
   input  logic             ken,
   input  logic             wbwt,
   input  logic             wr_hit,
   input  logic             wr_line_wt,
   output logic             cd_o,
   output logic             nw_o,
   output logic             inval,
   output logic [BEATS-1:0] fill_we_vec,
   output logic             line_alloc,
   output logic             line_wt,
   output logic             wr_bus
);

   localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("linefill_qual: BEATS must be a power of two, at least 2");
   end

   logic             we_en;
   logic [IDX_W-1:0] beat_idx;

   lfq_ctl_regs #(
      .CD_RST (CD_RST),
      .NW_RST (NW_RST)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_wr (ctl_wr),
      .cd_in  (cd_in),
      .nw_in  (nw_in),
      .cd_q   (cd_o),
      .nw_q   (nw_o),
      .inval  (inval)
   );

   lfq_fsm #(
      .BEATS (BEATS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .rd_start   (rd_start),
      .rdy        (rdy),
      .brdy       (brdy),
      .ken        (ken),
      .wbwt       (wbwt),
      .cd         (cd_o),
      .nw         (nw_o),
      .we_en      (we_en),
      .beat_idx   (beat_idx),
      .line_alloc (line_alloc),
      .line_wt    (line_wt)
   );

   lfq_strobe #(
      .BEATS (BEATS)
   ) u_strobe (
      .we_en    (we_en),
      .beat_idx (beat_idx),
      .we_vec   (fill_we_vec)
   );

   // A write-through line never absorbs a store silently.
   assign wr_bus = !wr_hit || wr_line_wt;

endmodule

// File: rtl/lfq_checker.sv
module lfq_checker #(
   parameter int BEATS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             ctl_wr,
   input logic             rdy,
   input logic             ken,
   input logic             cd_o,
   input logic             nw_o,
   input logic             inval,
   input logic [BEATS-1:0] fill_we_vec,
   input logic             line_alloc
);

   assert_inval_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      inval |-> (cd_o && nw_o));

   assert_soft_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !ctl_wr) |=> ($stable(cd_o) && $stable(nw_o) && !inval && !line_alloc));

   assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_we_vec));

   assert_ken_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we_vec[0] |-> ken);

   assert_cd_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we_vec[0] |-> !cd_o);

   assert_alloc_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_alloc |-> $past(fill_we_vec[BEATS-1]));

   assert_abort_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !line_alloc);

endmodule

bind linefill_qual lfq_checker #(.BEATS(BEATS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .ctl_wr      (ctl_wr),
   .rdy         (rdy),
   .ken         (ken),
   .cd_o        (cd_o),
   .nw_o        (nw_o),
   .inval       (inval),
   .fill_we_vec (fill_we_vec),
   .line_alloc  (line_alloc)
);

// File: tb/linefill_qual_test.sv
module linefill_qual_test;

   localparam int CLK_PERIOD = 10;
   localparam int BEATS      = 4;

   logic clk = 1'b0;
   logic rst_n, soft_rst, ctl_wr, cd_in, nw_in, rd_start, rdy, brdy, ken, wbwt;
   logic wr_hit, wr_line_wt;
   logic cd_o, nw_o, inval, line_alloc, line_wt, wr_bus;
   logic [BEATS-1:0] fill_we_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   linefill_qual #(.BEATS(BEATS)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_wr(ctl_wr),
      .cd_in(cd_in), .nw_in(nw_in), .rd_start(rd_start), .rdy(rdy),
      .brdy(brdy), .ken(ken), .wbwt(wbwt), .wr_hit(wr_hit),
      .wr_line_wt(wr_line_wt), .cd_o(cd_o), .nw_o(nw_o), .inval(inval),
      .fill_we_vec(fill_we_vec), .line_alloc(line_alloc), .line_wt(line_wt),
      .wr_bus(wr_bus)
   );

   typedef struct packed {
      logic       cd;
      logic       nw;
      logic       ken0;
      logic       wbwt0;
      logic       ken_r;
      logic       wbwt_r;
      logic [2:0] abort_at;   // 4 = burst runs to the end
      logic       exp_alloc;
      logic       exp_wt;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1},
      '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0},
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0},
      '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
      '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge_drive();
      @(posedge clk);
      #1;
   endtask

   task automatic set_ctl(input logic cd, input logic nw);
      ctl_wr = 1'b1; cd_in = cd; nw_in = nw;
      edge_drive();
      ctl_wr = 1'b0;
   endtask

   task automatic run_burst(input vec_t v);
      string req;
      logic  fill;
      set_ctl(v.cd, v.nw);
      rd_start = 1'b1;
      edge_drive();
      rd_start = 1'b0;
      fill = v.ken0 && !v.cd;
      req = (v.abort_at < 3'd4) ? "R9" : v.cd ? "R6" : !v.ken0 ? "R5" : "R4";
      for (int b = 0; b < BEATS; b++) begin
         if (b == int'(v.abort_at)) rdy = 1'b1;
         else                       brdy = 1'b1;
         ken  = (b == 0) ? v.ken0  : v.ken_r;
         wbwt = (b == 0) ? v.wbwt0 : v.wbwt_r;
         @(negedge clk);
         chk(req, 32'(fill_we_vec),
             (fill && b < int'(v.abort_at)) ? 32'(1 << b) : 32'd0);
         edge_drive();
         brdy = 1'b0; rdy = 1'b0; ken = 1'b0; wbwt = 1'b1;
         if (b == int'(v.abort_at)) break;
      end
      @(negedge clk);
      chk("R7", 32'(line_alloc), 32'(v.exp_alloc));
      if (v.exp_alloc) chk("R8", 32'(line_wt), 32'(v.exp_wt));
      edge_drive();
      chk("R7", 32'(line_alloc), 32'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      rst_n = 1'b0; soft_rst = 1'b0; ctl_wr = 1'b0; cd_in = 1'b0; nw_in = 1'b0;
      rd_start = 1'b0; rdy = 1'b0; brdy = 1'b0; ken = 1'b0; wbwt = 1'b1;
      wr_hit = 1'b0; wr_line_wt = 1'b0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", 32'(inval), 32'd1);
      chk("R1", 32'({cd_o, nw_o}), 32'd3);
      chk("R1", 32'(fill_we_vec), 32'd0);
      edge_drive();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'(inval), 32'd1);
      @(negedge clk);
      chk("R1", 32'(inval), 32'd0);
      chk("R1", 32'({cd_o, nw_o}), 32'd3);

      // table walk
      foreach (VECS[i]) run_burst(VECS[i]);

      // R3: control write with a simultaneous soft reset
      edge_drive();
      ctl_wr = 1'b1; cd_in = 1'b0; nw_in = 1'b1; soft_rst = 1'b1;
      edge_drive();
      ctl_wr = 1'b0; soft_rst = 1'b0;
      @(negedge clk);
      chk("R3", 32'({cd_o, nw_o}), 32'd1);

      // R2: soft reset on the last beat of a filling burst
      set_ctl(1'b0, 1'b0);
      rd_start = 1'b1;
      edge_drive();
      rd_start = 1'b0;
      for (int b = 0; b < BEATS - 1; b++) begin
         brdy = 1'b1; ken = 1'b1; wbwt = 1'b0;
         edge_drive();
      end
      brdy = 1'b1; soft_rst = 1'b1;
      @(negedge clk);
      chk("R2", 32'(fill_we_vec), 32'd0);
      edge_drive();
      brdy = 1'b0; soft_rst = 1'b0; ken = 1'b0; wbwt = 1'b1;
      @(negedge clk);
      chk("R2", 32'(line_alloc), 32'd0);
      chk("R2", 32'({cd_o, nw_o, inval}), 32'd0);
      edge_drive();
      run_burst(VECS[0]);   // R2: next burst starts fresh and allocates

      // R10: store routing
      wr_hit = 1'b0; wr_line_wt = 1'b0;
      #1 chk("R10", 32'(wr_bus), 32'd1);
      wr_hit = 1'b1; wr_line_wt = 1'b1;
      #1 chk("R10", 32'(wr_bus), 32'd1);
      wr_hit = 1'b1; wr_line_wt = 1'b0;
      #1 chk("R10", 32'(wr_bus), 32'd0);

      done = 1'b1;
      summary();
   end

endmodule